// File: doc/BRIEF.md
# Multi-Channel Edge-Selectable Input Capture

This block stamps external events with the time at which they happen. It takes a free-running timer count as an input and watches several external input pins, one per channel. When a pin changes level in a direction that its channel has been armed for, the block copies the timer count into that channel's capture register. It also raises that channel's interrupt flag, which stays up until software clears it.

Each channel has a two-bit edge selector. Its low bit arms the rising edge and its high bit arms the falling edge. With both bits set, the channel captures on either edge. With both bits clear, the channel never captures and never raises its flag.

Every pin passes through a two-flop synchronizer and then an edge detector. A detected edge loads the timer value present on the clock edge that ends the detection cycle. All interfaces are plain level signals, with no handshake. The capture registers can be read at any time, and software sees a new event by polling or taking the flag, then pulsing the per-channel clear.

Top module: `edge_capture_unit`

## Requirements
- R1: While reset is asserted and right after it, every capture register reads 0 and every interrupt flag reads 0.
- R2: When channel i has its rise bit (edge_sel bit 2i) set, a 0-to-1 change on cap_in[i] that is first sampled at clock edge k loads the timer_val present at edge k+2 into cap_val[16i+15:16i].
- R3: When channel i has its fall bit (edge_sel bit 2i+1) set, a 1-to-0 change on cap_in[i] is captured with the same timing as R2. A 0-to-1 change with only the fall bit set causes neither a capture nor a flag, and a 1-to-0 change with only the rise bit set likewise causes neither.
- R4: With both bits of a channel set, that channel captures on both the rising and the falling change.
- R5: With both bits of a channel clear, changes on its pin leave its capture register unchanged and its flag low.
- R6: Every capture sets irq[i] from edge k+2 onward. The flag stays set until a clock edge at which irq_clr[i] is high, and it falls only in that case.
- R7: A capture while irq[i] is already set still overwrites the capture register with the new timer value, and the flag stays set.
- R8: If irq_clr[i] is high at the same clock edge that a capture lands on channel i, the capture wins and irq[i] stays set.
- R9: An edge on one channel changes no other channel's capture register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timer_val | input | 16 | Current count of the external timer |
| cap_in | input | 4 | Asynchronous event pins, one per channel |
| edge_sel | input | 8 | Per-channel edge selection: bit 2i arms rising, bit 2i+1 arms falling |
| irq_clr | input | 4 | Per-channel flag clear strobe, sampled at the clock edge |
| cap_val | output | 64 | Capture registers, channel i at bits 16i+15:16i |
| irq | output | 4 | Per-channel interrupt flags |

## Verification
The hardest case to reach from the ports is a clear strobe that falls on exactly the clock edge where a capture lands. That edge is two synchronizer stages away from the pin change. The stimulus counts those clock edges from the negedge where it toggles the pin, and raises irq_clr only for the cycle that ends at edge k+2. It does this on a channel whose flag is already set, so a design that let the clear win would show a dropped flag. A sweep over every channel, every edge mode and both edge directions covers the remaining mode cases. The timer advances by an odd step on every clock, so each captured value pins down the exact capture cycle.

// File: rtl/cap_pkg.sv
package cap_pkg;
  // Per-channel edge arming. Low bit arms the rising edge, high bit the falling edge.
  typedef struct packed {
    logic fall_en;
    logic rise_en;
  } edge_cfg_t;

  localparam int unsigned CFG_W = $bits(edge_cfg_t);
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det
  import cap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  input  edge_cfg_t cfg,
  output logic      hit
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  logic rise, fall;
  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
  assign hit  = (rise & cfg.rise_en) | (fall & cfg.fall_en);
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          clr,
  input  logic [TW-1:0] tval,
  output logic [TW-1:0] cap,
  output logic          flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap <= '0;
    end else if (hit) begin
      cap <= tval;
    end
  end

  // A capture outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import cap_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned TW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TW-1:0]          timer_val,
  input  logic [NUM_CH-1:0]      cap_in,
  input  logic [NUM_CH*CFG_W-1:0] edge_sel,
  input  logic [NUM_CH-1:0]      irq_clr,
  output logic [NUM_CH*TW-1:0]   cap_val,
  output logic [NUM_CH-1:0]      irq
);
  logic [NUM_CH-1:0] pin_s;
  logic [NUM_CH-1:0] cap_hit;

  cap_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cap_in),
    .dout (pin_s)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    edge_cfg_t cfg;
    assign cfg = edge_cfg_t'(edge_sel[i*CFG_W +: CFG_W]);

    cap_edge_det u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (pin_s[i]),
      .cfg  (cfg),
      .hit  (cap_hit[i])
    );

    cap_channel #(.TW(TW)) u_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .hit  (cap_hit[i]),
      .clr  (irq_clr[i]),
      .tval (timer_val),
      .cap  (cap_val[i*TW +: TW]),
      .flag (irq[i])
    );
  end
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned TW     = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [TW-1:0]          timer_val,
  input logic [NUM_CH*2-1:0]    edge_sel,
  input logic [NUM_CH-1:0]      irq_clr,
  input logic [NUM_CH*TW-1:0]   cap_val,
  input logic [NUM_CH-1:0]      irq,
  input logic [NUM_CH-1:0]      cap_hit
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_LOAD_IS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_val[i*TW +: TW]) |-> cap_val[i*TW +: TW] == $past(timer_val)); // R2
    AST_HIT_NEEDS_ARMING: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit[i] |-> edge_sel[2*i +: 2] != 2'b00); // R5
    AST_HIT_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit[i] |=> irq[i]); // R8
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] && !irq_clr[i] |=> irq[i]); // R6
    AST_FLAG_DROP_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[i]) |-> $past(irq_clr[i])); // R6
    AST_LOAD_NEEDS_OWN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_val[i*TW +: TW]) |-> $past(cap_hit[i])); // R9
  end
endmodule

bind edge_capture_unit cap_checker #(.NUM_CH(NUM_CH), .TW(TW)) u_cap_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .timer_val(timer_val),
  .edge_sel (edge_sel),
  .irq_clr  (irq_clr),
  .cap_val  (cap_val),
  .irq      (irq),
  .cap_hit  (cap_hit)
);

// File: tb/test_edge_capture_unit.sv
`timescale 1ns/1ps
module test_edge_capture_unit;
  localparam int NCH = 4;
  localparam int TW  = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [TW-1:0]   tmr = 16'h1234;
  logic [NCH-1:0]  cap_in = '0;
  logic [2*NCH-1:0] edge_sel = '0;
  logic [NCH-1:0]  irq_clr = '0;
  logic [NCH*TW-1:0] cap_val;
  logic [NCH-1:0]  irq;

  int n_chk = 0;
  int n_err = 0;
  logic [TW-1:0] mdl_cap [NCH];
  logic [NCH-1:0] mdl_irq = '0;

  always #2 clk = ~clk;
  always @(posedge clk) tmr <= tmr + 16'd37;

  edge_capture_unit i_edge_capture_unit (
    .clk(clk), .rst_n(rst_n), .timer_val(tmr), .cap_in(cap_in),
    .edge_sel(edge_sel), .irq_clr(irq_clr), .cap_val(cap_val), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Called at a negedge. Toggles a pin and returns, at the negedge after the
  // capture edge, the timer value expected to be captured.
  task automatic do_edge(input int ch, output logic [TW-1:0] exp);
    cap_in[ch] = ~cap_in[ch];
    @(posedge clk);            // edge k
    @(posedge clk);            // edge k+1
    @(negedge clk);
    exp = tmr;                 // value present at edge k+2
    @(posedge clk);            // edge k+2
    @(negedge clk);
  endtask

  task automatic clear_all();
    irq_clr = '1;
    @(negedge clk);
    irq_clr = '0;
    mdl_irq = '0;
  endtask

  task automatic cmp_all(input int tgt, input string tag);
    for (int c = 0; c < NCH; c++) begin
      chk((c == tgt) ? tag : "R9", 32'(cap_val[c*TW +: TW]), 32'(mdl_cap[c]));
      chk((c == tgt) ? tag : "R9", 32'(irq[c]), 32'(mdl_irq[c]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [TW-1:0] e;
    logic [TW-1:0] e2;
    for (int c = 0; c < NCH; c++) mdl_cap[c] = '0;
    repeat (3) @(negedge clk);
    chk("R1", 32'(cap_val[31:0]), 32'h0);
    chk("R1", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 32'(cap_val[63:32]), 32'h0);
    chk("R1", 32'(irq), 32'h0);

    // Sweep: every channel, every mode, both directions; others armed for both.
    for (int mode = 0; mode < 4; mode++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        for (int c = 0; c < NCH; c++) edge_sel[2*c +: 2] = (c == ch) ? 2'(mode) : 2'b11;
        @(negedge clk);
        clear_all();
        for (int dir = 0; dir < 2; dir++) begin
          string tag;
          logic q;
          q = (dir == 0) ? edge_sel[2*ch] : edge_sel[2*ch+1];
          if (mode == 0)      tag = "R5";
          else if (mode == 3) tag = "R4";
          else if (dir == 0)  tag = "R2";
          else                tag = "R3";
          do_edge(ch, e);
          if (q) begin
            mdl_cap[ch] = e;
            mdl_irq[ch] = 1'b1;
          end
          cmp_all(ch, tag);
        end
      end
    end

    // R6: flag holds without a clear, then drops on a clear.
    edge_sel = '1;
    @(negedge clk);
    clear_all();
    do_edge(1, e);
    mdl_cap[1] = e; mdl_irq[1] = 1'b1;
    repeat (6) @(negedge clk);
    chk("R6", 32'(irq[1]), 32'h1);
    // R7: second capture while flag set overwrites the register.
    do_edge(1, e2);
    mdl_cap[1] = e2;
    chk("R7", 32'(cap_val[16 +: 16]), 32'(e2));
    chk("R7", 32'(irq[1]), 32'h1);
    chk("R7", 32'(e2 != e), 32'h1);
    irq_clr[1] = 1'b1;
    @(negedge clk);
    irq_clr[1] = 1'b0;
    mdl_irq[1] = 1'b0;
    chk("R6", 32'(irq[1]), 32'h0);
    cmp_all(1, "R6");

    // R8: clear strobe on the exact capture edge, flag already set beforehand.
    do_edge(2, e);
    mdl_cap[2] = e; mdl_irq[2] = 1'b1;
    cap_in[2] = ~cap_in[2];
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    e = tmr;
    irq_clr[2] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    irq_clr[2] = 1'b0;
    mdl_cap[2] = e;
    chk("R8", 32'(irq[2]), 32'h1);
    chk("R8", 32'(cap_val[32 +: 16]), 32'(e));
    cmp_all(2, "R8");

    summary();
  end
endmodule